// File: doc/BRIEF.md
# Aperture page remapping table

This block remaps addresses that fall inside one contiguous input window, the aperture, onto physical page frames. The window is split into 4 KiB pages and every page owns one table entry. Software reaches the table only through a small register set. A selector register takes an input address, which picks the entry. A data register then reads or writes that entry. A config register switches translation on and off.

A client presents an address on the lookup port. One cycle later the block answers with either a hit and the remapped physical address, or a fault. A fault is returned when translation is off, when the address lies outside the aperture, or when the selected entry is not marked valid.

The aperture base and the page count are parameters. Register reads answer one cycle after the read strobe, with a valid pulse. Because every register write takes effect at the clock edge where it is presented, a read of the config register also serves software as a flush point: any write issued before that read has landed by the time its answer appears.

Top module: `apt_remap`

## Requirements
- R1: After reset, translation is disabled and every entry holds zero, so any lookup faults and a config read returns 0.
- R2: The config register sits at byte offset 0x0. A write sets the enable from write-data bit 0 (1 enables, 0 disables). A read returns the enable in bit 0 and zeros above it. Every register read answers on reg_rdata, with reg_rvalid high, exactly one cycle after the reg_rd strobe.
- R3: The selector register sits at offset 0x4. It keeps the full 32-bit address last written, and a read returns that address.
- R4: The entry-data register sits at offset 0x8. A write stores bit 31 (the valid flag) and bits 30:12 (the frame) into the entry whose index is (selector - BASE) >> 12. A read returns that entry with bits 11:0 as zero.
- R5: While the selector holds an address outside the aperture, entry-data writes change no entry, and entry-data reads return 0.
- R6: An address is inside the aperture when it lies between BASE and BASE + PAGES*4096 - 1, both ends included. A lookup at BASE - 1 or at BASE + PAGES*4096 faults.
- R7: A lookup with lk_req high produces lk_valid one cycle later. When translation is enabled, the address is inside the aperture and the entry has bit 31 set, the answer is lk_hit=1, lk_fault=0 and lk_paddr = {0, entry frame bits 30:12, lk_addr bits 11:0}.
- R8: Every other lookup answers lk_fault=1, lk_hit=0 and lk_paddr=0. This includes lookups while translation is disabled and lookups on an entry whose bit 31 is clear, such as an all-zero entry. Without a request, hit and fault stay low.
- R9: A lookup issued in the same cycle as an entry-data write sees the old entry. A lookup issued in the following cycle sees the new entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_off | input | 4 | Register byte offset (0x0 config, 0x4 selector, 0x8 entry data) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read answer valid, one cycle after reg_rd |
| lk_req | input | 1 | Lookup request |
| lk_addr | input | 32 | Lookup input address |
| lk_valid | output | 1 | Lookup answer valid, one cycle after lk_req |
| lk_hit | output | 1 | Lookup translated |
| lk_fault | output | 1 | Lookup refused |
| lk_paddr | output | 32 | Remapped physical address, zero on fault |

## Verification
A corrupted entry or a wrong index computation appears on the very next lookup of the affected page, one cycle after the request. It shows there as a wrong frame in lk_paddr or as a hit and fault swapped. It also appears on an entry-data read through the selector, one cycle after the read strobe. A stuck enable or a wrong window bound turns hits into faults at the edge pages, which is why the pages just inside and just outside both ends are looked up directly. The order of a table write against a lookup is observable only in the lookup issued in the same cycle and the one issued right after it, so those two are compared back to back.

// File: rtl/apt_pkg.sv
package apt_pkg;
  localparam int WORD_W     = 32;
  localparam int PAGE_SHIFT = 12;
  localparam int FRAME_W    = WORD_W - 1 - PAGE_SHIFT;
  localparam int ENTRY_W    = FRAME_W + 1;

  localparam logic [3:0] OFF_CFG = 4'h0;
  localparam logic [3:0] OFF_SEL = 4'h4;
  localparam logic [3:0] OFF_ENT = 4'h8;

  // inclusive window test, computed one bit wider so the top end cannot wrap
  function automatic logic in_window(input logic [WORD_W-1:0] a,
                                     input logic [WORD_W-1:0] base,
                                     input int unsigned pages);
    logic [WORD_W:0] x, lo, hi;
    x  = {1'b0, a};
    lo = {1'b0, base};
    hi = lo + ((WORD_W+1)'(pages) << PAGE_SHIFT) - (WORD_W+1)'(1);
    return (x >= lo) && (x <= hi);
  endfunction

  function automatic logic [WORD_W-1:0] page_offset(input logic [WORD_W-1:0] a,
                                                    input logic [WORD_W-1:0] base);
    logic [WORD_W-1:0] d;
    d = a - base;
    return d >> PAGE_SHIFT;
  endfunction

  function automatic logic [ENTRY_W-1:0] pack_entry(input logic [WORD_W-1:0] w);
    return w[WORD_W-1:PAGE_SHIFT];
  endfunction

  function automatic logic [WORD_W-1:0] unpack_entry(input logic [ENTRY_W-1:0] e);
    return {e, {PAGE_SHIFT{1'b0}}};
  endfunction

  function automatic logic [WORD_W-1:0] compose(input logic [FRAME_W-1:0] frame,
                                                input logic [PAGE_SHIFT-1:0] off);
    return {1'b0, frame, off};
  endfunction
endpackage

// File: rtl/apt_table.sv
module apt_table
  import apt_pkg::*;
#(
  parameter int unsigned PAGES = 32,
  parameter int          IDX_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [IDX_W-1:0]   widx,
  input  logic [ENTRY_W-1:0] wdata,
  input  logic [IDX_W-1:0]   ridx_a,
  output logic [ENTRY_W-1:0] rdata_a,
  input  logic [IDX_W-1:0]   ridx_b,
  output logic [ENTRY_W-1:0] rdata_b
);
  logic [ENTRY_W-1:0] ent [PAGES];

  for (genvar g = 0; g < int'(PAGES); g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        ent[g] <= '0;
      else if (we && (widx == IDX_W'(g)))
        ent[g] <= wdata;
    end
  end

  always_comb begin
    rdata_a = '0;
    rdata_b = '0;
    if (int'(ridx_a) < int'(PAGES)) rdata_a = ent[ridx_a];
    if (int'(ridx_b) < int'(PAGES)) rdata_b = ent[ridx_b];
  end
endmodule

// File: rtl/apt_regs.sv
module apt_regs
  import apt_pkg::*;
#(
  parameter logic [31:0] BASE  = 32'h0400_0000,
  parameter int unsigned PAGES = 32,
  parameter int          IDX_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [3:0]         reg_off,
  input  logic [WORD_W-1:0]  reg_wdata,
  output logic [WORD_W-1:0]  reg_rdata,
  output logic               reg_rvalid,
  input  logic [ENTRY_W-1:0] ent_rdata,
  output logic [IDX_W-1:0]   sel_idx,
  output logic               sel_ok,
  output logic               ent_wr_ev,
  output logic               tbl_we,
  output logic [ENTRY_W-1:0] tbl_wdata,
  output logic               en
);
  logic              en_q;
  logic [WORD_W-1:0] sel_q;
  logic [WORD_W-1:0] rdata_q;
  logic              rvalid_q;
  logic [WORD_W-1:0] rd_next;
  logic              cfg_wr_ev;
  logic              sel_wr_ev;

  assign cfg_wr_ev = reg_wr && (reg_off == OFF_CFG);
  assign sel_wr_ev = reg_wr && (reg_off == OFF_SEL);
  assign ent_wr_ev = reg_wr && (reg_off == OFF_ENT);

  assign sel_ok    = in_window(sel_q, BASE, PAGES);
  assign sel_idx   = IDX_W'(page_offset(sel_q, BASE));
  assign tbl_we    = ent_wr_ev && sel_ok;
  assign tbl_wdata = pack_entry(reg_wdata);

  always_comb begin
    case (reg_off)
      OFF_CFG: rd_next = {{(WORD_W-1){1'b0}}, en_q};
      OFF_SEL: rd_next = sel_q;
      OFF_ENT: rd_next = sel_ok ? unpack_entry(ent_rdata) : '0;
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      sel_q    <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      if (cfg_wr_ev) en_q  <= reg_wdata[0];
      if (sel_wr_ev) sel_q <= reg_wdata;
      rvalid_q <= reg_rd;
      if (reg_rd) rdata_q <= rd_next;
    end
  end

  assign en         = en_q;
  assign reg_rdata  = rdata_q;
  assign reg_rvalid = rvalid_q;
endmodule

// File: rtl/apt_xlate.sv
module apt_xlate
  import apt_pkg::*;
#(
  parameter logic [31:0] BASE  = 32'h0400_0000,
  parameter int unsigned PAGES = 32,
  parameter int          IDX_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               lk_req,
  input  logic [WORD_W-1:0]  lk_addr,
  output logic [IDX_W-1:0]   lk_idx,
  input  logic [ENTRY_W-1:0] entry,
  output logic               lk_win,
  output logic               lk_valid,
  output logic               lk_hit,
  output logic               lk_fault,
  output logic [WORD_W-1:0]  lk_paddr
);
  logic              hit_c;
  logic              valid_q, hit_q, fault_q;
  logic [WORD_W-1:0] paddr_q;

  assign lk_win = in_window(lk_addr, BASE, PAGES);
  assign lk_idx = IDX_W'(page_offset(lk_addr, BASE));
  assign hit_c  = en && lk_win && entry[ENTRY_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      hit_q   <= 1'b0;
      fault_q <= 1'b0;
      paddr_q <= '0;
    end else begin
      valid_q <= lk_req;
      if (lk_req) begin
        hit_q   <= hit_c;
        fault_q <= !hit_c;
        paddr_q <= hit_c ? compose(entry[FRAME_W-1:0], lk_addr[PAGE_SHIFT-1:0]) : '0;
      end else begin
        hit_q   <= 1'b0;
        fault_q <= 1'b0;
        paddr_q <= '0;
      end
    end
  end

  assign lk_valid = valid_q;
  assign lk_hit   = hit_q;
  assign lk_fault = fault_q;
  assign lk_paddr = paddr_q;
endmodule

// File: rtl/apt_remap.sv
module apt_remap
  import apt_pkg::*;
#(
  parameter logic [31:0] BASE  = 32'h0400_0000,
  parameter int unsigned PAGES = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [3:0]  reg_off,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        reg_rvalid,
  input  logic        lk_req,
  input  logic [31:0] lk_addr,
  output logic        lk_valid,
  output logic        lk_hit,
  output logic        lk_fault,
  output logic [31:0] lk_paddr
);
  localparam int IDX_W = (PAGES > 1) ? $clog2(PAGES) : 1;

  logic [IDX_W-1:0]   sel_idx, lk_idx;
  logic               sel_ok, ent_wr_ev, tbl_we, en, lk_win;
  logic [ENTRY_W-1:0] tbl_wdata, ent_sel, ent_lk;

  apt_regs #(.BASE(BASE), .PAGES(PAGES), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_off(reg_off), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid), .ent_rdata(ent_sel), .sel_idx(sel_idx),
    .sel_ok(sel_ok), .ent_wr_ev(ent_wr_ev), .tbl_we(tbl_we),
    .tbl_wdata(tbl_wdata), .en(en)
  );

  apt_table #(.PAGES(PAGES), .IDX_W(IDX_W)) u_table (
    .clk(clk), .rst_n(rst_n), .we(tbl_we), .widx(sel_idx), .wdata(tbl_wdata),
    .ridx_a(sel_idx), .rdata_a(ent_sel), .ridx_b(lk_idx), .rdata_b(ent_lk)
  );

  apt_xlate #(.BASE(BASE), .PAGES(PAGES), .IDX_W(IDX_W)) u_xlate (
    .clk(clk), .rst_n(rst_n), .en(en), .lk_req(lk_req), .lk_addr(lk_addr),
    .lk_idx(lk_idx), .entry(ent_lk), .lk_win(lk_win), .lk_valid(lk_valid),
    .lk_hit(lk_hit), .lk_fault(lk_fault), .lk_paddr(lk_paddr)
  );
endmodule

// File: rtl/apt_checker.sv
module apt_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_rd,
  input logic        reg_rvalid,
  input logic        lk_req,
  input logic [31:0] lk_addr,
  input logic        lk_valid,
  input logic        lk_hit,
  input logic        lk_fault,
  input logic [31:0] lk_paddr,
  input logic        en,
  input logic        lk_win
);
  // R2: read answer one cycle after strobe, and only then
  a_r2_read_answers: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> reg_rvalid);
  a_r2_no_spurious_answer: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> !reg_rvalid);
  // R7: lookup answer timing and offset pass-through
  a_r7_answer_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> lk_valid);
  a_r7_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_paddr[11:0] == $past(lk_addr[11:0])));
  // R8: exactly one outcome per answer, quiet otherwise, zero address on fault
  a_r8_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> $onehot({lk_hit, lk_fault}));
  a_r8_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> (!lk_hit && !lk_fault));
  a_r8_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
    lk_fault |-> (lk_paddr == 32'd0));
  a_r8_disabled_faults: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_req && !en) |=> lk_fault);
  // R6: outside the window always faults
  a_r6_outside_faults: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_req && !lk_win) |=> lk_fault);
endmodule

bind apt_remap apt_checker u_chk (
  .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_rvalid(reg_rvalid),
  .lk_req(lk_req), .lk_addr(lk_addr), .lk_valid(lk_valid), .lk_hit(lk_hit),
  .lk_fault(lk_fault), .lk_paddr(lk_paddr), .en(en), .lk_win(lk_win)
);

// File: tb/tb_apt_remap.sv
module tb_apt_remap;
  localparam int          CLK_P = 10;
  localparam logic [31:0] BASE  = 32'h0400_0000;
  localparam int          PAGES = 32;
  localparam longint      SPAN  = longint'(PAGES) * 4096;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0]  reg_off = 4'h0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_rvalid;
  logic        lk_req = 1'b0;
  logic [31:0] lk_addr = '0;
  logic        lk_valid, lk_hit, lk_fault;
  logic [31:0] lk_paddr;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  logic        m_en;
  logic [31:0] m_sel;
  logic [31:0] m_tab [PAGES];

  always #(CLK_P/2) clk = ~clk;

  apt_remap #(.BASE(BASE), .PAGES(PAGES)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_off(reg_off), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid), .lk_req(lk_req), .lk_addr(lk_addr),
    .lk_valid(lk_valid), .lk_hit(lk_hit), .lk_fault(lk_fault),
    .lk_paddr(lk_paddr)
  );

  function automatic bit b_inside(input logic [31:0] a);
    longint x = longint'(a);
    return (x >= longint'(BASE)) && (x < longint'(BASE) + SPAN);
  endfunction

  function automatic int b_page(input logic [31:0] a);
    return int'((longint'(a) - longint'(BASE)) / 4096);
  endfunction

  function automatic logic [31:0] b_expect_pa(input logic [31:0] a);
    logic [31:0] e;
    if (!m_en || !b_inside(a)) return 32'd0;
    e = m_tab[b_page(a)];
    if (!e[31]) return 32'd0;
    return {1'b0, e[30:12], a[11:0]};
  endfunction

  function automatic bit b_expect_hit(input logic [31:0] a);
    logic [31:0] e;
    if (!m_en || !b_inside(a)) return 1'b0;
    e = m_tab[b_page(a)];
    return e[31];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] off, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_off = off; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    if (off == 4'h0) m_en = d[0];
    if (off == 4'h4) m_sel = d;
    if (off == 4'h8 && b_inside(m_sel)) m_tab[b_page(m_sel)] = {d[31:12], 12'h000};
  endtask

  task automatic rd(input logic [3:0] off, output logic [31:0] d, input string req);
    @(negedge clk);
    reg_rd = 1'b1; reg_off = off;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
    chk(reg_rvalid === 1'b1, req, {31'd0, reg_rvalid}, 32'd1);
  endtask

  task automatic look(input logic [31:0] a, input string req);
    bit eh;
    logic [31:0] ep;
    eh = b_expect_hit(a);
    ep = b_expect_pa(a);
    @(negedge clk);
    lk_req = 1'b1; lk_addr = a;
    @(negedge clk);
    lk_req = 1'b0;
    chk(lk_valid === 1'b1 && lk_hit === eh && lk_fault === !eh, req,
        {29'd0, lk_valid, lk_hit, lk_fault}, {29'd0, 1'b1, eh, !eh});
    chk(lk_paddr === ep, req, lk_paddr, ep);
  endtask

  task automatic set_entry(input logic [31:0] a, input logic [31:0] d);
    wr(4'h4, a);
    wr(4'h8, d);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, a, v, old_e, new_e;
    logic [31:0] endp;
    void'($urandom(32'd1357));
    m_en = 1'b0; m_sel = '0;
    for (int i = 0; i < PAGES; i++) m_tab[i] = '0;
    endp = BASE + 32'(SPAN) - 32'd1;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(4'h0, d, "R1 config after reset");
    chk(d === 32'd0, "R1 config after reset", d, 32'd0);
    chk(lk_valid === 1'b0 && lk_hit === 1'b0 && lk_fault === 1'b0, "R1 idle outputs",
        {29'd0, lk_valid, lk_hit, lk_fault}, 32'd0);
    look(BASE + 32'h1234, "R1 lookup faults while disabled");
    wr(4'h0, 32'd1);
    look(BASE + 32'h5678, "R1 reset entry is unmapped");

    // R2 config read and disable
    rd(4'h0, d, "R2 config read valid");
    chk(d === 32'd1, "R2 config enabled", d, 32'd1);

    // R3 selector readback
    wr(4'h4, 32'hDEAD_BEEF);
    rd(4'h4, d, "R3 selector read valid");
    chk(d === 32'hDEAD_BEEF, "R3 selector readback", d, 32'hDEAD_BEEF);

    // R4 entry write and read
    set_entry(BASE + 32'h3000, 32'hA123_4FFF);
    rd(4'h8, d, "R4 entry read valid");
    chk(d === 32'hA123_4000, "R4 entry readback low bits zero", d, 32'hA123_4000);
    look(BASE + 32'h3ABC, "R7 hit composes frame and offset");

    // R5 out of window selection
    set_entry(BASE + 32'h0000, 32'h8000_1000);
    wr(4'h4, endp + 32'd1);
    wr(4'h8, 32'hFFFF_F000);
    rd(4'h8, d, "R5 outside read valid");
    chk(d === 32'd0, "R5 outside selection reads zero", d, 32'd0);
    wr(4'h4, BASE - 32'd4096);
    wr(4'h8, 32'hFFFF_F000);
    wr(4'h4, BASE);
    rd(4'h8, d, "R5 entry 0 read valid");
    chk(d === 32'h8000_1000, "R5 entry 0 unchanged", d, 32'h8000_1000);
    wr(4'h4, BASE + 32'h1F000);
    rd(4'h8, d, "R5 last entry read valid");
    chk(d === 32'd0, "R5 last entry unchanged", d, 32'd0);

    // R6 window edges
    set_entry(endp, 32'h8777_7000);
    look(BASE - 32'd1, "R6 below base faults");
    look(BASE, "R6 base hits");
    look(endp, "R6 top hits");
    look(endp + 32'd1, "R6 above top faults");

    // R8 invalid entry and disabled translation
    set_entry(BASE + 32'h5000, 32'h7FFF_F000);
    look(BASE + 32'h5010, "R8 invalid entry faults");
    wr(4'h0, 32'd0);
    look(BASE + 32'h3ABC, "R8 disabled faults");
    rd(4'h0, d, "R2 config read after disable");
    chk(d === 32'd0, "R2 config disabled", d, 32'd0);
    wr(4'h0, 32'd1);

    // R9 write versus lookup order
    old_e = m_tab[3];
    new_e = 32'h8055_5000;
    wr(4'h4, BASE + 32'h3000);
    @(negedge clk);
    reg_wr = 1'b1; reg_off = 4'h8; reg_wdata = new_e;
    lk_req = 1'b1; lk_addr = BASE + 32'h3044;
    @(negedge clk);
    reg_wr = 1'b0;
    chk(lk_hit === 1'b1 && lk_paddr === {1'b0, old_e[30:12], 12'h044},
        "R9 same cycle lookup sees old entry", lk_paddr, {1'b0, old_e[30:12], 12'h044});
    @(negedge clk);
    lk_req = 1'b0;
    chk(lk_hit === 1'b1 && lk_paddr === {1'b0, new_e[30:12], 12'h044},
        "R9 next lookup sees new entry", lk_paddr, {1'b0, new_e[30:12], 12'h044});
    m_tab[3] = new_e;

    // random mix
    for (int it = 0; it < 400; it++) begin
      int op;
      op = int'($urandom_range(0, 9));
      if (op < 3) begin
        a = BASE + ($urandom_range(0, PAGES - 1) << 12) + $urandom_range(0, 4095);
        v = $urandom;
        set_entry(a, v);
        rd(4'h8, d, "R4 random entry read valid");
        chk(d === {v[31:12], 12'h000}, "R4 random entry readback", d, {v[31:12], 12'h000});
      end else if (op == 3) begin
        wr(4'h0, {31'd0, ($urandom_range(0, 3) != 0)});
      end else begin
        case ($urandom_range(0, 3))
          0:       a = BASE - 32'd1 - $urandom_range(0, 8191);
          1:       a = endp + 32'd1 + $urandom_range(0, 8191);
          default: a = BASE + $urandom_range(0, int'(SPAN) - 1);
        endcase
        look(a, "R7 R8 random lookup");
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule